// File: doc/BRIEF.md
# Floating-Point Control and Status Register

This block holds the floating-point control state of a processor core: a 3-bit dynamic rounding mode and five sticky exception flags. Software reaches it through a CSR access port. The port supports read, write, bit-set and bit-clear operations. Three addresses view the state in different ways: the flags alone, the rounding mode alone, or both packed into one word.

Retiring floating-point instructions report their exception conditions on an accrual input. Those conditions are ORed into the flags, and the flags stay set until software clears them.

The block also resolves the rounding field of an instruction into the rounding mode that is actually used. A field of 111 selects the stored dynamic mode. Any result that is not a defined mode is flagged as an illegal instruction.

All outputs are registered. Read data, the address-hit indication and the resolved rounding mode appear one cycle after the inputs that produce them.

Top module: `fp_csr_unit`

## Requirements
- R1: While `rst` is high on a clock edge, the state and all outputs clear to zero after that edge: stored mode, flags, `csr_rdata`, `csr_hit`, `rm_eff` and `rm_illegal`.
- R2: Address 0x001 views the flags at bits [4:0], with NX at bit 0, UF at bit 1, OF at bit 2, DZ at bit 3 and NV at bit 4. Address 0x002 views the rounding mode at bits [2:0]. Address 0x003 views the full register, with the mode at [7:5] and the flags at [4:0]. Read bits above the addressed field are zero. Any other address gives `csr_hit`=0 and `csr_rdata`=0, and changes nothing.
- R3: `csr_op` encodings are 00 read, 01 write, 10 set (OR with write data) and 11 clear (AND with inverted write data). An operation uses only the write-data bits of the addressed field and changes only that field.
- R4: With `csr_en` high, `csr_rdata` in the next cycle holds the value the addressed field had before the access, and `csr_hit` is 1 for a valid address.
- R5: In the cycle after `insn_rm` is presented, `rm_eff` equals `insn_rm` if it is not 111. If it is 111, `rm_eff` equals the stored mode as it was before that clock edge.
- R6: `rm_illegal` is 1 exactly when the resolved mode is 101, 110 or 111. Defined modes are 000 nearest-even, 001 toward zero, 010 toward minus infinity, 011 toward plus infinity and 100 nearest-max-magnitude.
- R7: When `acc_valid` is high, `acc_flags` (same bit order as R2) is ORed into the flags. Flags are never cleared except by a CSR access.
- R8: When a CSR access and an accrual occur in the same cycle, the CSR result is formed first and the accrued flags are ORed onto it.
- R9: A read operation (00) leaves the stored mode and flags unchanged, whatever the write data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_en | input | 1 | CSR access strobe |
| csr_op | input | 2 | Access operation: read, write, set or clear |
| csr_addr | input | 12 | CSR address |
| csr_wdata | input | 32 | Write, set or clear data |
| csr_rdata | output | 32 | Old value of the addressed field, one cycle later |
| csr_hit | output | 1 | Previous access targeted a valid address |
| acc_valid | input | 1 | Accrual strobe from a retiring instruction |
| acc_flags | input | 5 | Exception flags to accrue |
| insn_rm | input | 3 | Instruction rounding field |
| rm_eff | output | 3 | Resolved rounding mode, one cycle later |
| rm_illegal | output | 1 | Resolved mode is undefined |
| cur_frm | output | 3 | Stored dynamic rounding mode |
| cur_flags | output | 5 | Stored sticky flags |

## Verification
The bench targets several corner cases:
- A write to the flags address landing in the same cycle as an accrual. A design that applied the accrual first would lose the accrued bits.
- Set and clear through the full-register address, where a wrong field mask would corrupt the rounding mode.
- A dynamic field of 111 sampled in the cycle the mode is rewritten. A design that forwarded the new mode would report the wrong effective mode.
- Undefined stored modes (101 to 111) reached through the dynamic field, which must raise the illegal flag.
- Unmapped addresses and read operations carrying nonzero write data, which a loose decoder would let modify the state.

// File: rtl/fp_csr_pkg.sv
package fp_csr_pkg;
  typedef enum logic [1:0] {
    OP_READ  = 2'b00,
    OP_WRITE = 2'b01,
    OP_SET   = 2'b10,
    OP_CLEAR = 2'b11
  } csr_op_e;

  localparam logic [2:0] RM_DYNAMIC = 3'b111;
  localparam logic [2:0] RM_LAST_OK = 3'b100;
endpackage

// File: rtl/fp_csr_field_update.sv
module fp_csr_field_update #(
  parameter int W = 5
) (
  input  logic [1:0]   op,
  input  logic [W-1:0] old_val,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] new_val
);
  import fp_csr_pkg::*;

  always_comb begin
    unique case (csr_op_e'(op))
      OP_WRITE: new_val = wdata;
      OP_SET:   new_val = old_val | wdata;
      OP_CLEAR: new_val = old_val & ~wdata;
      default:  new_val = old_val;
    endcase
  end
endmodule

// File: rtl/fp_rm_resolve.sv
module fp_rm_resolve #(
  parameter int RM_W = 3
) (
  input  logic [RM_W-1:0] insn_rm,
  input  logic [RM_W-1:0] stored_rm,
  output logic [RM_W-1:0] eff_rm,
  output logic            bad_rm
);
  import fp_csr_pkg::*;

  always_comb begin
    eff_rm = (insn_rm == RM_W'(RM_DYNAMIC)) ? stored_rm : insn_rm;
    bad_rm = (eff_rm > RM_W'(RM_LAST_OK));
  end
endmodule

// File: rtl/fp_csr_unit.sv
module fp_csr_unit #(
  parameter int          ADDR_W     = 12,
  parameter int          DATA_W     = 32,
  parameter int          FLAG_W     = 5,
  parameter int          RM_W       = 3,
  parameter logic [11:0] ADDR_FLAGS = 12'h001,
  parameter logic [11:0] ADDR_MODE  = 12'h002,
  parameter logic [11:0] ADDR_FULL  = 12'h003
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              csr_en,
  input  logic [1:0]        csr_op,
  input  logic [ADDR_W-1:0] csr_addr,
  input  logic [DATA_W-1:0] csr_wdata,
  output logic [DATA_W-1:0] csr_rdata,
  output logic              csr_hit,
  input  logic              acc_valid,
  input  logic [FLAG_W-1:0] acc_flags,
  input  logic [RM_W-1:0]   insn_rm,
  output logic [RM_W-1:0]   rm_eff,
  output logic              rm_illegal,
  output logic [RM_W-1:0]   cur_frm,
  output logic [FLAG_W-1:0] cur_flags
);
  localparam int FULL_W = RM_W + FLAG_W;

  logic [FLAG_W-1:0] flags_q, flags_csr, flags_nxt, flags_upd;
  logic [RM_W-1:0]   frm_q, frm_nxt, frm_upd;
  logic [FULL_W-1:0] full_old, full_upd;
  logic [DATA_W-1:0] rd_nxt;
  logic              sel_flags, sel_mode, sel_full;
  logic [RM_W-1:0]   eff_c;
  logic              bad_c;

  assign sel_flags = csr_en && (csr_addr == ADDR_W'(ADDR_FLAGS));
  assign sel_mode  = csr_en && (csr_addr == ADDR_W'(ADDR_MODE));
  assign sel_full  = csr_en && (csr_addr == ADDR_W'(ADDR_FULL));
  assign full_old  = {frm_q, flags_q};

  fp_csr_field_update #(.W(FLAG_W)) u_upd_flags (
    .op(csr_op), .old_val(flags_q), .wdata(csr_wdata[FLAG_W-1:0]), .new_val(flags_upd)
  );
  fp_csr_field_update #(.W(RM_W)) u_upd_mode (
    .op(csr_op), .old_val(frm_q), .wdata(csr_wdata[RM_W-1:0]), .new_val(frm_upd)
  );
  fp_csr_field_update #(.W(FULL_W)) u_upd_full (
    .op(csr_op), .old_val(full_old), .wdata(csr_wdata[FULL_W-1:0]), .new_val(full_upd)
  );

  fp_rm_resolve #(.RM_W(RM_W)) u_rm (
    .insn_rm(insn_rm), .stored_rm(frm_q), .eff_rm(eff_c), .bad_rm(bad_c)
  );

  always_comb begin
    flags_csr = flags_q;
    frm_nxt   = frm_q;
    rd_nxt    = '0;
    if (sel_flags) begin
      flags_csr              = flags_upd;
      rd_nxt[FLAG_W-1:0]     = flags_q;
    end else if (sel_mode) begin
      frm_nxt                = frm_upd;
      rd_nxt[RM_W-1:0]       = frm_q;
    end else if (sel_full) begin
      flags_csr              = full_upd[FLAG_W-1:0];
      frm_nxt                = full_upd[FULL_W-1:FLAG_W];
      rd_nxt[FULL_W-1:0]     = full_old;
    end
    // accrual lands on top of the software result
    flags_nxt = flags_csr | (acc_valid ? acc_flags : '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q    <= '0;
      frm_q      <= '0;
      csr_rdata  <= '0;
      csr_hit    <= 1'b0;
      rm_eff     <= '0;
      rm_illegal <= 1'b0;
    end else begin
      flags_q    <= flags_nxt;
      frm_q      <= frm_nxt;
      csr_rdata  <= rd_nxt;
      csr_hit    <= sel_flags | sel_mode | sel_full;
      rm_eff     <= eff_c;
      rm_illegal <= bad_c;
    end
  end

  assign cur_frm   = frm_q;
  assign cur_flags = flags_q;
endmodule

// File: rtl/fp_csr_unit_chk.sv
module fp_csr_unit_chk #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int FLAG_W = 5,
  parameter int RM_W   = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              csr_en,
  input logic [ADDR_W-1:0] csr_addr,
  input logic [DATA_W-1:0] csr_rdata,
  input logic              csr_hit,
  input logic              acc_valid,
  input logic [FLAG_W-1:0] acc_flags,
  input logic [RM_W-1:0]   insn_rm,
  input logic [RM_W-1:0]   rm_eff,
  input logic [RM_W-1:0]   cur_frm,
  input logic [FLAG_W-1:0] cur_flags
);
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
    csr_rdata[DATA_W-1:RM_W+FLAG_W] == '0); // R2
  AST_HIT_RANGE: assert property (@(posedge clk) disable iff (rst)
    csr_hit |-> ($past(csr_addr) >= ADDR_W'(1) && $past(csr_addr) <= ADDR_W'(3))); // R2
  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !csr_en |=> $stable(cur_frm)); // R3
  AST_STATIC_RM: assert property (@(posedge clk) disable iff (rst)
    (insn_rm != 3'b111) |=> (rm_eff == $past(insn_rm))); // R5
  AST_DYNAMIC_RM: assert property (@(posedge clk) disable iff (rst)
    (insn_rm == 3'b111) |=> (rm_eff == $past(cur_frm))); // R5
  AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (rst)
    !csr_en |=> ((cur_flags & $past(cur_flags)) == $past(cur_flags))); // R7
  AST_ACCRUE_LAST: assert property (@(posedge clk) disable iff (rst)
    acc_valid |=> ((cur_flags & $past(acc_flags)) == $past(acc_flags))); // R8
endmodule

bind fp_csr_unit fp_csr_unit_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .FLAG_W(FLAG_W), .RM_W(RM_W)
) u_chk (
  .clk(clk), .rst(rst), .csr_en(csr_en), .csr_addr(csr_addr),
  .csr_rdata(csr_rdata), .csr_hit(csr_hit), .acc_valid(acc_valid),
  .acc_flags(acc_flags), .insn_rm(insn_rm), .rm_eff(rm_eff),
  .cur_frm(cur_frm), .cur_flags(cur_flags)
);

// File: tb/fp_csr_unit_tb_top.sv
module fp_csr_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        csr_en;
  logic [1:0]  csr_op;
  logic [11:0] csr_addr;
  logic [31:0] csr_wdata;
  logic [31:0] csr_rdata;
  logic        csr_hit;
  logic        acc_valid;
  logic [4:0]  acc_flags;
  logic [2:0]  insn_rm;
  logic [2:0]  rm_eff;
  logic        rm_illegal;
  logic [2:0]  cur_frm;
  logic [4:0]  cur_flags;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [2:0] m_frm;
  logic [4:0] m_flags;

  always #4 clk = ~clk;

  fp_csr_unit dut_i (
    .clk(clk), .rst(rst), .csr_en(csr_en), .csr_op(csr_op), .csr_addr(csr_addr),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .csr_hit(csr_hit),
    .acc_valid(acc_valid), .acc_flags(acc_flags), .insn_rm(insn_rm),
    .rm_eff(rm_eff), .rm_illegal(rm_illegal), .cur_frm(cur_frm), .cur_flags(cur_flags)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] apply_op(input logic [1:0] op, input logic [7:0] oldv,
                                          input logic [7:0] wd);
    case (op)
      2'b01:   return wd;
      2'b10:   return oldv | wd;
      2'b11:   return oldv & ~wd;
      default: return oldv;
    endcase
  endfunction

  task automatic step(input string req, input logic en, input logic [1:0] op,
                      input logic [11:0] addr, input logic [31:0] wd, input logic av,
                      input logic [4:0] af, input logic [2:0] irm);
    logic [31:0] e_rd;
    logic        e_hit;
    logic [2:0]  e_eff;
    logic [2:0]  n_frm;
    logic [4:0]  n_flags;
    logic [7:0]  full;
    @(negedge clk);
    csr_en = en; csr_op = op; csr_addr = addr; csr_wdata = wd;
    acc_valid = av; acc_flags = af; insn_rm = irm;
    e_rd = '0; e_hit = 1'b0; n_frm = m_frm; n_flags = m_flags;
    if (en && addr == 12'h001) begin
      e_hit = 1'b1; e_rd = {27'b0, m_flags};
      n_flags = apply_op(op, {3'b0, m_flags}, {3'b0, wd[4:0]}) & 8'h1f;
    end else if (en && addr == 12'h002) begin
      e_hit = 1'b1; e_rd = {29'b0, m_frm};
      n_frm = 3'(apply_op(op, {5'b0, m_frm}, {5'b0, wd[2:0]}));
    end else if (en && addr == 12'h003) begin
      e_hit = 1'b1; e_rd = {24'b0, m_frm, m_flags};
      full = apply_op(op, {m_frm, m_flags}, wd[7:0]);
      n_frm = full[7:5]; n_flags = full[4:0];
    end
    if (av) n_flags = n_flags | af;
    e_eff = (irm == 3'b111) ? m_frm : irm;
    @(posedge clk); #1;
    chk(req, "csr_hit", {31'b0, csr_hit}, {31'b0, e_hit});
    chk(req, "csr_rdata", csr_rdata, e_rd);
    chk(req, "cur_frm", {29'b0, cur_frm}, {29'b0, n_frm});
    chk(req, "cur_flags", {27'b0, cur_flags}, {27'b0, n_flags});
    chk("R5", "rm_eff", {29'b0, rm_eff}, {29'b0, e_eff});
    chk("R6", "rm_illegal", {31'b0, rm_illegal}, {31'b0, (e_eff > 3'd4)});
    m_frm = n_frm; m_flags = n_flags;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20231));
    rst = 1'b1; csr_en = 0; csr_op = 0; csr_addr = 0; csr_wdata = 0;
    acc_valid = 0; acc_flags = 0; insn_rm = 0;
    m_frm = 0; m_flags = 0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "reset rdata", csr_rdata, 32'h0);
    chk("R1", "reset hit", {31'b0, csr_hit}, 32'h0);
    chk("R1", "reset frm", {29'b0, cur_frm}, 32'h0);
    chk("R1", "reset flags", {27'b0, cur_flags}, 32'h0);
    chk("R1", "reset eff", {29'b0, rm_eff}, 32'h0);
    chk("R1", "reset illegal", {31'b0, rm_illegal}, 32'h0);
    @(negedge clk); rst = 1'b0;

    // R2 / R3: full-register write then read back at each view
    step("R2", 1, 2'b01, 12'h003, 32'hFFFF_FF7A, 0, 5'h0, 3'd0); // frm=3 flags=1a
    step("R4", 1, 2'b00, 12'h003, 32'h0, 0, 5'h0, 3'd7);
    step("R2", 1, 2'b00, 12'h001, 32'h0, 0, 5'h0, 3'd1);
    step("R2", 1, 2'b00, 12'h002, 32'h0, 0, 5'h0, 3'd2);
    // R3 clear/set via full view keeps other field
    step("R3", 1, 2'b11, 12'h003, 32'h0000_0012, 0, 5'h0, 3'd4);
    step("R3", 1, 2'b10, 12'h002, 32'hFFFF_FFF4, 0, 5'h0, 3'd3);
    // R9: read with nonzero data
    step("R9", 1, 2'b00, 12'h001, 32'hFFFF_FFFF, 0, 5'h0, 3'd0);
    // R2: unmapped address ignored
    step("R2", 1, 2'b01, 12'h004, 32'hFFFF_FFFF, 0, 5'h0, 3'd0);
    step("R2", 1, 2'b01, 12'h000, 32'hFFFF_FFFF, 0, 5'h0, 3'd0);
    // R5/R6: mode write and dynamic resolve in same cycle
    step("R5", 1, 2'b01, 12'h002, 32'h5, 0, 5'h0, 3'd7);
    step("R6", 0, 2'b00, 12'h000, 32'h0, 0, 5'h0, 3'd7);
    step("R6", 0, 2'b00, 12'h000, 32'h0, 0, 5'h0, 3'd6);
    step("R6", 0, 2'b00, 12'h000, 32'h0, 0, 5'h0, 3'd4);
    step("R5", 1, 2'b01, 12'h002, 32'h2, 0, 5'h0, 3'd7);
    step("R5", 0, 2'b00, 12'h000, 32'h0, 0, 5'h0, 3'd7);
    // R7: accrual sticky
    step("R7", 1, 2'b01, 12'h001, 32'h0, 0, 5'h0, 3'd0);
    step("R7", 0, 2'b00, 12'h000, 32'h0, 1, 5'h01, 3'd0);
    step("R7", 0, 2'b00, 12'h000, 32'h0, 1, 5'h10, 3'd0);
    step("R7", 0, 2'b00, 12'h000, 32'h0, 1, 5'h00, 3'd0);
    // R8: write/clear with accrual in same cycle
    step("R8", 1, 2'b01, 12'h001, 32'h0, 1, 5'h04, 3'd0);
    step("R8", 1, 2'b11, 12'h003, 32'hFF, 1, 5'h08, 3'd0);

    for (int i = 0; i < 3000; i++) begin
      logic [11:0] a;
      int sel;
      sel = $urandom_range(0, 5);
      a = (sel < 4) ? 12'(sel) : 12'($urandom);
      step("R3", 1'($urandom), 2'($urandom), a, $urandom, 1'($urandom_range(0, 3) == 0),
           5'($urandom), 3'($urandom));
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule